// File: doc/BRIEF.md
# Capture/Compare Timer with Prescaler

A single-channel general-purpose timer. A programmable prescaler turns the system clock, or an externally gated enable, into counting ticks. On each tick a 32-bit up-counter advances and is compared with a reference value. A match sets a sticky event flag and drives an output pin, either as a pulse or as a toggle. Depending on a mode bit, the counter then either restarts from zero or keeps counting. With restart selected, the match period is (prescale+1)*(reference+1) clocks.

An input-capture pin is synchronised and edge-detected. The selected edge latches the running count into a capture register and sets a second event flag. Software reaches mode, event, reference, capture and counter through a simple write strobe and a combinational read port. Software clears event flags by writing a one to them. An interrupt line combines each flag with its own enable bit.

Top module: `capcmp_timer`

## Requirements
- R1: After reset every register reads 0, and `tmr_out` and `irq` are 0. While mode bit 0 (run) is 0, the prescaler and the counter are held at 0 and `tmr_out` is 0.
- R2: Mode bits [2:1] choose the tick source: 00 = none, 01 = every clock, 1x = only clocks where `ext_tick` is 1. The counter advances once every (P+1) source clocks, where P is mode bits [15:8].
- R3: When the counter equals the reference on a tick, event bit 1 is set. With mode bit 3 = 0 the counter keeps counting past the reference.
- R4: With mode bit 3 = 1 the counter returns to 0 on the match tick, so event bit 1 is set every (P+1)*(reference+1) clocks.
- R5: Mode bits [7:6] choose the capture edge: 00 = off, 01 = rising, 10 = falling, 11 = both. `cap_in` passes through two synchroniser flops and an edge flop, so the counter value is latched into the capture register on the third clock edge after the pin changes. A capture sets event bit 0. Capture works only while running.
- R6: With mode bit 5 = 0, `tmr_out` is 1 for exactly one tick interval after a match tick and 0 otherwise. With mode bit 5 = 1, `tmr_out` inverts on every match tick.
- R7: Writing to the event register clears each flag whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R8: `irq` = (event bit 1 AND mode bit 4) OR (event bit 0 AND mode bit 16).
- R9: Register addresses are 0 mode, 1 event, 2 reference, 3 capture and 4 counter. Other addresses read 0. Writes to the capture and counter addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| cap_in | input | 1 | Asynchronous capture trigger pin |
| ext_tick | input | 1 | Synchronous external count enable |
| tmr_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Reference of zero with no prescaling.** The counter matches on every clock. This exercises a software clear that lands in the same cycle as a hardware set; a design that lets the clear win would drop flags software depends on.
- **Match period under restart.** A design with the restart or the prescaler compare off by one would produce a period one tick or one clock too long or too short.
- **Capture edge selections and synchroniser latency.** Each selection is exercised against the pin's latency; a miscounted synchroniser latches a neighbouring count, and a wrong edge decode captures on the wrong transition.
- **Gated counting, pulse versus toggle output, stop, and ignored writes.** The bench gates counting with an irregular enable pattern, switches between pulse and toggle output, stops the timer mid-count, and writes to read-only addresses. These catch counters that drift, outputs that stick, and registers that take stray writes.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE    = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVENT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_REFV    = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPTURE = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd4;

  localparam int MB_RUN      = 0;
  localparam int MB_SRC_LSB  = 1;
  localparam int MB_RESTART  = 3;
  localparam int MB_REF_IE   = 4;
  localparam int MB_TOGGLE   = 5;
  localparam int MB_CAP_LSB  = 6;
  localparam int MB_PS_LSB   = 8;

  localparam int EV_CAP = 0;
  localparam int EV_REF = 1;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_ANY  = 2'b11
  } cap_edge_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_EXT0 = 2'b10,
    SRC_EXT1 = 2'b11
  } tick_src_e;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  logic [PS_W-1:0] pcnt_q, pcnt_d;
  logic            pcnt_en;

  assign tick = run && src_en && (pcnt_q == ps);

  always_comb begin
    pcnt_en = 1'b0;
    pcnt_d  = pcnt_q;
    if (!run) begin
      pcnt_en = 1'b1;
      pcnt_d  = '0;
    end else if (src_en) begin
      pcnt_en = 1'b1;
      pcnt_d  = tick ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/cct_capture_sync.sv
module cct_capture_sync
  import cct_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      pin,
  input  cap_edge_e edge_sel,
  output logic      hit
);
  localparam int CHAIN_W = SYNC_N + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               cur, prev, rise, fall;

  assign chain_d = {chain_q[CHAIN_W-2:0], pin};
  assign cur     = chain_q[SYNC_N-1];
  assign prev    = chain_q[SYNC_N];
  assign rise    = cur && !prev;
  assign fall    = !cur && prev;

  always_comb begin
    unique case (edge_sel)
      CAP_RISE: hit = run && rise;
      CAP_FALL: hit = run && fall;
      CAP_ANY:  hit = run && (rise || fall);
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/cct_count_core.sv
module cct_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] refv,
  input  logic             restart,
  input  logic             toggle,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt,
  output logic             out
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d, upd_en, match;

  assign match     = (cnt_q == refv);
  assign match_evt = tick && match;
  assign cnt       = cnt_q;
  assign out       = out_q;

  always_comb begin
    upd_en = 1'b0;
    cnt_d  = cnt_q;
    out_d  = out_q;
    if (!run) begin
      upd_en = 1'b1;
      cnt_d  = '0;
      out_d  = 1'b0;
    end else if (tick) begin
      upd_en = 1'b1;
      cnt_d  = (match && restart) ? '0 : cnt_q + 1'b1;
      out_d  = toggle ? (out_q ^ match) : match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  input  logic              ext_tick,
  output logic              tmr_out,
  output logic              irq
);
  localparam int CIE_BIT = MB_PS_LSB + PS_W;
  localparam int MODE_W  = CIE_BIT + 1;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  refv_q, refv_d, cap_q, cap_d, cnt_q;
  logic [1:0]        ev_q, ev_d, ev_clr;
  logic              mode_we, refv_we, cap_we;
  logic              run, src_en, tick, match_evt, cap_hit;
  tick_src_e         src_sel;
  cap_edge_e         edge_sel;

  assign run      = mode_q[MB_RUN];
  assign src_sel  = tick_src_e'(mode_q[MB_SRC_LSB +: 2]);
  assign edge_sel = cap_edge_e'(mode_q[MB_CAP_LSB +: 2]);
  assign src_en   = (src_sel == SRC_SYS) || (src_sel[1] && ext_tick);

  cct_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .src_en(src_en),
    .ps(mode_q[MB_PS_LSB +: PS_W]), .tick(tick)
  );

  cct_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .refv(refv_q),
    .restart(mode_q[MB_RESTART]), .toggle(mode_q[MB_TOGGLE]),
    .cnt(cnt_q), .match_evt(match_evt), .out(tmr_out)
  );

  cct_capture_sync #(.SYNC_N(2)) u_capsync (
    .clk(clk), .rst_n(rst_n), .run(run), .pin(cap_in),
    .edge_sel(edge_sel), .hit(cap_hit)
  );

  // register next-state
  always_comb begin
    mode_we = wr_en && (wr_addr == A_MODE);
    refv_we = wr_en && (wr_addr == A_REFV);
    cap_we  = cap_hit;
    mode_d  = wr_data[MODE_W-1:0];
    refv_d  = wr_data;
    cap_d   = cnt_q;
    ev_clr  = (wr_en && (wr_addr == A_EVENT)) ? wr_data[1:0] : 2'b00;
    ev_d    = ev_q & ~ev_clr;
    if (cap_hit)   ev_d[EV_CAP] = 1'b1;
    if (match_evt) ev_d[EV_REF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      refv_q <= '0;
      cap_q  <= '0;
      ev_q   <= '0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (refv_we) refv_q <= refv_d;
      if (cap_we)  cap_q  <= cap_d;
      ev_q <= ev_d;
    end
  end

  assign irq = (ev_q[EV_REF] && mode_q[MB_REF_IE]) ||
               (ev_q[EV_CAP] && mode_q[CIE_BIT]);

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_MODE:    rd_data[MODE_W-1:0] = mode_q;
      A_EVENT:   rd_data[1:0]        = ev_q;
      A_REFV:    rd_data             = refv_q;
      A_CAPTURE: rd_data             = cap_q;
      A_COUNT:   rd_data             = cnt_q;
      default:   rd_data             = '0;
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] refv,
  input logic             restart,
  input logic             toggle,
  input logic [1:0]       ev,
  input logic             ref_clr,
  input logic             out
);
  p_halt_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0) && !out);

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  p_ref_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == refv) |=> ev[1]);

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == refv && restart) |=> (cnt == '0));

  p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == refv && toggle) |=> (out != $past(out)));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[1] && !ref_clr) |=> ev[1]);
endmodule

bind capcmp_timer cct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt(cnt_q),
  .refv(refv_q), .restart(mode_q[3]), .toggle(mode_q[5]), .ev(ev_q),
  .ref_clr(wr_en && (wr_addr == 3'd1) && wr_data[1]), .out(tmr_out)
);

// File: tb/test_capcmp_timer.sv
module test_capcmp_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        cap_in, ext_tick, tmr_out, irq;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;

  capcmp_timer i_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_in(cap_in), .ext_tick(ext_tick), .tmr_out(tmr_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [16:0] m_mode;
  logic [31:0] m_refv, m_cap, m_cnt;
  logic [7:0]  m_pcnt;
  logic [1:0]  m_ev;
  logic        m_out, m_s1, m_s2, m_s3;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {15'd0, m_mode};
      3'd1: return {30'd0, m_ev};
      3'd2: return m_refv;
      3'd3: return m_cap;
      3'd4: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R9 mode readback";
      3'd1: return "R7 event register";
      3'd2: return "R9 reference readback";
      3'd3: return "R5 capture register";
      3'd4: return "R2 counter value";
      default: return "R9 unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = '0; m_refv = '0; m_cap = '0; m_cnt = '0; m_pcnt = '0;
      m_ev = '0; m_out = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
    end else begin
      bit src, tk, mt, hit, rise, fall;
      logic [1:0] ev_n;
      src  = (m_mode[2:1] == 2'b01) || (m_mode[2] && ext_tick);
      tk   = m_mode[0] && src && (m_pcnt == m_mode[15:8]);
      mt   = (m_cnt == m_refv);
      rise = m_s2 && !m_s3;
      fall = !m_s2 && m_s3;
      case (m_mode[7:6])
        2'b01:   hit = rise;
        2'b10:   hit = fall;
        2'b11:   hit = rise || fall;
        default: hit = 1'b0;
      endcase
      hit  = hit && m_mode[0];
      ev_n = m_ev;
      if (wr_en && wr_addr == 3'd1) ev_n = ev_n & ~wr_data[1:0];
      if (hit) ev_n[0] = 1'b1;
      if (tk && mt) ev_n[1] = 1'b1;
      m_ev = ev_n;
      if (hit) m_cap = m_cnt;
      if (!m_mode[0]) begin
        m_pcnt = '0; m_cnt = '0; m_out = 1'b0;
      end else if (src) begin
        if (tk) begin
          m_pcnt = '0;
          m_out  = m_mode[5] ? (m_out ^ mt) : mt;
          m_cnt  = (mt && m_mode[3]) ? 32'd0 : m_cnt + 32'd1;
        end else begin
          m_pcnt = m_pcnt + 8'd1;
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (wr_en && wr_addr == 3'd0) m_mode = wr_data[16:0];
      if (wr_en && wr_addr == 3'd2) m_refv = wr_data;
    end
    #2;
    if (cmp_on) begin
      chk(rd_data == m_read(rd_addr), tag_of(rd_addr), rd_data, m_read(rd_addr));
      chk(tmr_out == m_out, "R6 output pin", {31'd0, tmr_out}, {31'd0, m_out});
      chk(irq == ((m_ev[1] && m_mode[4]) || (m_ev[0] && m_mode[16])),
          "R8 interrupt", {31'd0, irq}, {31'd0, ((m_ev[1] && m_mode[4]) || (m_ev[0] && m_mode[16]))});
    end
  end

  function automatic logic [31:0] mw(input bit run, input logic [1:0] src, input bit rst_cnt,
                                     input bit rie, input bit tog, input logic [1:0] cedge,
                                     input logic [7:0] ps, input bit cie);
    return {15'd0, cie, ps, cedge, tog, rie, rst_cnt, src, run};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = 3'd4; cap_in = 1'b0; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1 chk(rd_data == 32'd0, "R1 reset register", rd_data, 32'd0);
    end
    chk(tmr_out == 1'b0 && irq == 1'b0, "R1 reset pins", {30'd0, tmr_out, irq}, 32'd0);
    @(negedge clk);

    // restart mode, prescale 2, reference 4
    wr(3'd2, 32'd4);
    wr(3'd0, mw(1, 2'b01, 1, 1, 0, 2'b00, 8'd2, 0));
    rd_addr = 3'd1;
    n = 0;
    while (rd_data[1] == 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk(rd_data[1] == 1'b1, "R3 reference flag sets", rd_data, 32'd2);
    wr(3'd1, 32'd2);
    n = 0;
    while (rd_data[1] == 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk(n == (2 + 1) * (4 + 1) - 1, "R4 match period", 32'(n), 32'd14);
    rd_addr = 3'd4;
    repeat (30) @(negedge clk);

    // toggle output, no prescale
    wr(3'd2, 32'd3);
    wr(3'd0, mw(1, 2'b01, 1, 0, 1, 2'b00, 8'd0, 0));
    repeat (40) @(negedge clk);

    // free run past the reference
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd5);
    wr(3'd0, mw(1, 2'b01, 0, 1, 0, 2'b00, 8'd0, 0));
    repeat (20) @(negedge clk);
    chk(rd_data > 32'd5, "R3 free run passes reference", rd_data, 32'd6);

    // externally gated ticks, prescale 1
    wr(3'd0, 32'd0);
    wr(3'd0, mw(1, 2'b10, 1, 0, 0, 2'b00, 8'd1, 0));
    for (int i = 0; i < 60; i++) begin
      ext_tick = (i % 3) != 0;
      @(negedge clk);
    end
    ext_tick = 1'b0;
    wr(3'd0, mw(1, 2'b00, 1, 0, 0, 2'b00, 8'd0, 0));
    repeat (5) @(negedge clk);

    // capture edges
    for (int e = 0; e < 4; e++) begin
      wr(3'd1, 32'd3);
      wr(3'd0, mw(1, 2'b01, 0, 0, 0, 2'(e), 8'd0, 1));
      rd_addr = 3'd3;
      for (int p = 0; p < 3; p++) begin
        cap_in = 1'b1; repeat (5 + p) @(negedge clk);
        cap_in = 1'b0; repeat (7) @(negedge clk);
      end
      rd_addr = 3'd1;
      repeat (2) @(negedge clk);
    end
    wr(3'd1, 32'd1);

    // clear collides with hardware set
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd0, mw(1, 2'b01, 1, 1, 0, 2'b00, 8'd0, 0));
    rd_addr = 3'd1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      wr(3'd1, 32'd3);
      chk(rd_data[1] == 1'b1, "R7 set wins over clear", rd_data, 32'd2);
    end

    // ignored writes and unmapped reads
    wr(3'd3, 32'hdead_beef);
    rd_addr = 3'd3; @(negedge clk);
    wr(3'd4, 32'd1234);
    rd_addr = 3'd4; @(negedge clk);
    rd_addr = 3'd5; @(negedge clk);
    rd_addr = 3'd7; @(negedge clk);

    // stop clears counter
    rd_addr = 3'd4;
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(rd_data == 32'd0 && tmr_out == 1'b0, "R1 stopped timer cleared", rd_data, 32'd0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule